// File: doc/BRIEF.md
# Receive Statistics Counter Bank

This block keeps two host-visible frame statistics for an Ethernet receive MAC. One counter, 8 bits wide, counts address-matched frames that were cut short by a receive buffer overrun the host can see. The other counter, 16 bits wide, counts address-matched frames that arrived without any error. The receive path reports each finished frame as a one-cycle strobe, together with an outcome code and an address-match flag. Neither counter moves unless the global statistics enable is high.

The host reaches the bank through a byte-wide register port. Read data is combinational in the read cycle. Reading a counter returns its value and clears it. The 16-bit counter is read low byte first. That read copies the high byte into a shadow register, where the host can fetch it afterwards.

When either counter steps into the value 0xC0, a sticky update flag is set. The flag drives an interrupt status output and stays set until the host writes a 1 to clear it.

Top module: `rx_stat_bank`

## Requirements
- R1: The lost-frame counter is 8 bits, reads 0x00 after reset, and steps from 0xFF back to 0x00.
- R2: The good-frame counter is 16 bits, reads 0x0000 after reset, and steps from 0xFFFF back to 0x0000.
- R3: A read at offset 0x79 returns the lost-frame count in the same cycle and leaves that counter at zero.
- R4: On the clock edge where either counter steps from 0xBF to 0xC0, the update flag becomes 1. The flag appears on `upd_irq` and as bit 0 of offset 0x40.
- R5: While `stat_en` is 0, neither counter changes on events, and reads still return and clear.
- R6: The lost-frame counter counts a strobe only when the outcome is 5 (overrun during reception) and `rx_addr_match` is 1. Outcome 6 (buffer full at frame start) and unmatched frames are not counted.
- R7: The good-frame counter counts a strobe only when the outcome is 0 (clean) and `rx_addr_match` is 1. Outcomes 1 (too long), 2 (FCS), 3 (length), 4 (alignment) and 5 (overrun) are not counted.
- R8: A read at offset 0x72 returns bits 7:0 of the good-frame count, copies bits 15:8 into a shadow register readable at 0x73, and clears the counter.
- R9: The update flag stays set until a write to offset 0x40 with bit 0 equal to 1. If the flag is raised in the same cycle as that clear, the raise wins.
- R10: When a counter is read in the same cycle as one of its events, the read returns the old value and the counter ends at 1.
- R11: Writes to 0x79, 0x72 and 0x73 have no effect. Reads of unmapped offsets return 0. `reg_rdata` is 0 when `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stat_en | input | 1 | Global statistics enable |
| rx_evt | input | 1 | One-cycle end-of-frame strobe |
| rx_outcome | input | 3 | Frame outcome code (0 clean … 6 full at start) |
| rx_addr_match | input | 1 | Destination address passed the filter |
| reg_rd | input | 1 | Host read strobe |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 8 | Host byte offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid in the read cycle |
| upd_irq | output | 1 | Sticky statistics-update status |

## Verification
The assertions assume that one host access uses a single address per cycle. A read and a write may be raised together only when both target the flag register. They also assume that outcome codes are mutually exclusive per strobe, so at most one counter steps per cycle. The stimulus follows both assumptions:
- Each cycle carries at most one frame strobe with one outcome code.
- Host writes either stand alone or coincide only with frame events, never with a read of another offset.

This keeps the raise-versus-clear case on the flag register reachable.

// File: rtl/rx_stat_pkg.sv
// Shared types for the receive statistics bank.
// Assumes outcome codes fit in three bits and are mutually exclusive per frame.
package rx_stat_pkg;

    localparam int OUTCOME_W = 3;

    typedef enum logic [OUTCOME_W-1:0] {
        RX_CLEAN         = 3'd0,
        RX_TOO_LONG      = 3'd1,
        RX_FCS_BAD       = 3'd2,
        RX_LEN_BAD       = 3'd3,
        RX_ALIGN_BAD     = 3'd4,
        RX_OVERRUN       = 3'd5,
        RX_FULL_AT_START = 3'd6,
        RX_RESERVED      = 3'd7
    } rx_outcome_e;

endpackage

// File: rtl/rx_stat_qualify.sv
// Turns an end-of-frame strobe and its outcome into per-counter increments.
// Assumes one strobe carries one outcome. Unmatched frames never count.
module rx_stat_qualify
    import rx_stat_pkg::*;
(
    input  logic        stat_en,
    input  logic        ev_valid,
    input  logic        ev_addr_hit,
    input  rx_outcome_e ev_code,
    output logic        inc_lost,
    output logic        inc_good
);

    logic accept;

    // Decide which counter, if any, this frame advances.
    always_comb begin
        accept   = stat_en && ev_valid && ev_addr_hit;
        inc_lost = accept && (ev_code == RX_OVERRUN);
        inc_good = accept && (ev_code == RX_CLEAN);
    end

endmodule

// File: rtl/rx_stat_counter.sv
// Wrapping event counter with clear-on-read and a threshold-entry pulse.
// Assumes clr comes from a host read; an event in the same cycle leaves 1.
module rx_stat_counter #(
    parameter int W      = 8,
    parameter int THRESH = 192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         hit
);

    localparam logic [W-1:0] PRE_HIT = W'(THRESH - 1);
    localparam logic [W-1:0] ONE     = W'(1);

    // Count, wrap naturally, and restart on read without losing an event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? ONE : '0;
        end else if (inc) begin
            cnt <= cnt + ONE;
        end
    end

    // Pulse when the next edge moves the count into the threshold.
    always_comb begin
        hit = inc && !clr && (cnt == PRE_HIT);
    end

endmodule

// File: rtl/rx_stat_bank.sv
// Receive statistics bank: lost-frame and good-frame counters behind a
// byte register port, with a sticky update flag set on threshold entry.
// Assumes one host address per cycle; read data is combinational.
module rx_stat_bank
    import rx_stat_pkg::*;
#(
    parameter int                LOST_W      = 8,
    parameter int                GOOD_W      = 16,
    parameter int                THRESH      = 192,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] OFF_LOST    = 8'h79,
    parameter logic [ADDR_W-1:0] OFF_GOOD_LO = 8'h72,
    parameter logic [ADDR_W-1:0] OFF_GOOD_HI = 8'h73,
    parameter logic [ADDR_W-1:0] OFF_FLAG    = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_en,
    input  logic              rx_evt,
    input  logic [2:0]        rx_outcome,
    input  logic              rx_addr_match,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              upd_irq
);

    localparam int HI_W = GOOD_W - 8;

    logic              inc_lost;
    logic              inc_good;
    logic [LOST_W-1:0] lost_cnt;
    logic [GOOD_W-1:0] good_cnt;
    logic              hit_lost;
    logic              hit_good;
    logic              sel_lost;
    logic              sel_glo;
    logic              sel_ghi;
    logic              sel_flag;
    logic              rd_lost;
    logic              rd_good;
    logic              flag_clr;
    logic [HI_W-1:0]   shadow_hi;
    logic              upd_flag;
    logic              unused_wdata;

    rx_stat_qualify u_qual (
        .stat_en     (stat_en),
        .ev_valid    (rx_evt),
        .ev_addr_hit (rx_addr_match),
        .ev_code     (rx_outcome_e'(rx_outcome)),
        .inc_lost    (inc_lost),
        .inc_good    (inc_good)
    );

    rx_stat_counter #(.W(LOST_W), .THRESH(THRESH)) u_lost (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_lost),
        .clr   (rd_lost),
        .cnt   (lost_cnt),
        .hit   (hit_lost)
    );

    rx_stat_counter #(.W(GOOD_W), .THRESH(THRESH)) u_good (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (inc_good),
        .clr   (rd_good),
        .cnt   (good_cnt),
        .hit   (hit_good)
    );

    // Decode the host offset into register selects and side effects.
    always_comb begin
        sel_lost     = (reg_addr == OFF_LOST);
        sel_glo      = (reg_addr == OFF_GOOD_LO);
        sel_ghi      = (reg_addr == OFF_GOOD_HI);
        sel_flag     = (reg_addr == OFF_FLAG);
        rd_lost      = reg_rd && sel_lost;
        rd_good      = reg_rd && sel_glo;
        flag_clr     = reg_wr && sel_flag && reg_wdata[0];
        unused_wdata = ^reg_wdata[7:1];
    end

    // Return the selected register in the read cycle, zero otherwise.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (sel_lost) begin
                reg_rdata = 8'(lost_cnt);
            end else if (sel_glo) begin
                reg_rdata = good_cnt[7:0];
            end else if (sel_ghi) begin
                reg_rdata = 8'(shadow_hi);
            end else if (sel_flag) begin
                reg_rdata = {7'b0, upd_flag};
            end
        end
    end

    // Capture the upper byte when the low byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_hi <= '0;
        end else if (rd_good) begin
            shadow_hi <= good_cnt[GOOD_W-1:8];
        end
    end

    // Sticky update flag: threshold entry sets it and beats a host clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_flag <= 1'b0;
        end else if (hit_lost || hit_good) begin
            upd_flag <= 1'b1;
        end else if (flag_clr) begin
            upd_flag <= 1'b0;
        end
    end

    assign upd_irq = upd_flag;

endmodule

// File: rtl/rx_stat_bank_chk.sv
// Property checker for rx_stat_bank, bound to every instance of it.
// Assumes the host never presents two addresses in one cycle.
module rx_stat_bank_chk #(
    parameter int          LOST_W      = 8,
    parameter int          GOOD_W      = 16,
    parameter logic [7:0]  OFF_LOST    = 8'h79,
    parameter logic [7:0]  OFF_GOOD_LO = 8'h72,
    parameter logic [7:0]  OFF_FLAG    = 8'h40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stat_en,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [7:0]        reg_addr,
    input logic              wdata0,
    input logic              inc_lost,
    input logic              inc_good,
    input logic [LOST_W-1:0] lost_cnt,
    input logic [GOOD_W-1:0] good_cnt,
    input logic              upd_flag
);

    logic rd_l;
    logic rd_g;
    logic clr_w;

    // Local decode of host side effects, kept apart from the design's own.
    always_comb begin
        rd_l  = reg_rd && (reg_addr == OFF_LOST);
        rd_g  = reg_rd && (reg_addr == OFF_GOOD_LO);
        clr_w = reg_wr && (reg_addr == OFF_FLAG) && wdata0;
    end

    AST_LOST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_lost && !rd_l) |=> (lost_cnt == $past(lost_cnt) + LOST_W'(1))); // R1

    AST_LOST_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_l && !inc_lost) |=> (lost_cnt == '0)); // R3

    AST_GOOD_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_g && !inc_good) |=> (good_cnt == '0)); // R8

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en |-> (!inc_lost && !inc_good)); // R5

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc_lost, inc_good})); // R6

    AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_good && !rd_g && good_cnt == GOOD_W'(191)) |=> upd_flag); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !clr_w) |=> upd_flag); // R9

    AST_RD_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_l && inc_lost) |=> (lost_cnt == LOST_W'(1))); // R10

endmodule

bind rx_stat_bank rx_stat_bank_chk #(
    .LOST_W      (LOST_W),
    .GOOD_W      (GOOD_W),
    .OFF_LOST    (OFF_LOST),
    .OFF_GOOD_LO (OFF_GOOD_LO),
    .OFF_FLAG    (OFF_FLAG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_en  (stat_en),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wdata0   (reg_wdata[0]),
    .inc_lost (inc_lost),
    .inc_good (inc_good),
    .lost_cnt (lost_cnt),
    .good_cnt (good_cnt),
    .upd_flag (upd_flag)
);

// File: tb/rx_stat_bank_bench.sv
// Self-checking bench: a behavioural model is stepped every clock and
// compared with read data and the interrupt output.
module rx_stat_bank_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       stat_en;
    logic       rx_evt;
    logic [2:0] rx_outcome;
    logic       rx_addr_match;
    logic       reg_rd;
    logic       reg_wr;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       upd_irq;

    int   errors = 0;
    int   checks = 0;
    int   m_lost = 0;
    int   m_good = 0;
    int   m_shadow = 0;
    int   m_flag = 0;
    logic [7:0] last_rd;

    localparam logic [2:0] OC_CLEAN = 3'd0, OC_LONG = 3'd1, OC_FCS = 3'd2,
                           OC_LEN = 3'd3, OC_ALIGN = 3'd4, OC_OVR = 3'd5,
                           OC_FULL = 3'd6;

    always #4 clk = ~clk;

    rx_stat_bank u_rx_stat_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_en       (stat_en),
        .rx_evt        (rx_evt),
        .rx_outcome    (rx_outcome),
        .rx_addr_match (rx_addr_match),
        .reg_rd        (reg_rd),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .upd_irq       (upd_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One clock: drive, compare at the falling edge, then step the model.
    task automatic cyc(input bit ev, input logic [2:0] oc, input bit mt,
                       input bit rd, input bit wr, input logic [7:0] ad,
                       input logic [7:0] wd);
        int    e;
        string tag;
        bit    il, ig, rl, rg;
        rx_evt = ev; rx_outcome = oc; rx_addr_match = mt;
        reg_rd = rd; reg_wr = wr; reg_addr = ad; reg_wdata = wd;
        @(negedge clk);
        e = 0;
        tag = "R11 rdata";
        if (rd) begin
            if (ad == 8'h79) begin e = m_lost; tag = "R3 rdata"; end
            else if (ad == 8'h72) begin e = m_good % 256; tag = "R8 rdata"; end
            else if (ad == 8'h73) begin e = m_shadow; tag = "R8 rdata"; end
            else if (ad == 8'h40) begin e = m_flag; tag = "R9 rdata"; end
        end
        last_rd = reg_rdata;
        check(reg_rdata == 8'(e), tag, int'(reg_rdata), e);
        check(int'(upd_irq) == m_flag, "R4 irq level", int'(upd_irq), m_flag);
        @(posedge clk);
        il = stat_en && ev && mt && (oc == OC_OVR);
        ig = stat_en && ev && mt && (oc == OC_CLEAN);
        rl = rd && (ad == 8'h79);
        rg = rd && (ad == 8'h72);
        if (rg) m_shadow = m_good / 256;
        if ((il && !rl && m_lost == 191) || (ig && !rg && m_good == 191)) m_flag = 1;
        else if (wr && ad == 8'h40 && wd[0]) m_flag = 0;
        m_lost = rl ? int'(il) : (m_lost + int'(il)) % 256;
        m_good = rg ? int'(ig) : (m_good + int'(ig)) % 65536;
        #1;
    endtask

    task automatic evts(input int n, input logic [2:0] oc, input bit mt);
        for (int i = 0; i < n; i++) cyc(1'b1, oc, mt, 1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic rd_exp(input logic [7:0] ad, input int exp, input string req);
        cyc(1'b0, OC_CLEAN, 1'b0, 1'b1, 1'b0, ad, 8'h00);
        check(last_rd == 8'(exp), req, int'(last_rd), exp);
    endtask

    task automatic wr_reg(input logic [7:0] ad, input logic [7:0] wd);
        cyc(1'b0, OC_CLEAN, 1'b0, 1'b0, 1'b1, ad, wd);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired before the sequence ended");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; stat_en = 1'b0; rx_evt = 1'b0; rx_outcome = '0;
        rx_addr_match = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset values: R1, R2, R8, R9
        rd_exp(8'h79, 0, "R1 reset lost");
        rd_exp(8'h72, 0, "R2 reset good");
        rd_exp(8'h73, 0, "R8 reset shadow");
        rd_exp(8'h40, 0, "R9 reset flag");

        stat_en = 1'b1;
        // Lost-frame qualification: R6, R3
        evts(3, OC_OVR, 1'b1);
        evts(2, OC_OVR, 1'b0);
        evts(2, OC_FULL, 1'b1);
        rd_exp(8'h79, 3, "R6 lost qualify");
        rd_exp(8'h79, 0, "R3 cleared by read");

        // Good-frame qualification: R7
        evts(4, OC_CLEAN, 1'b1);
        evts(1, OC_LONG, 1'b1);
        evts(1, OC_FCS, 1'b1);
        evts(1, OC_LEN, 1'b1);
        evts(1, OC_ALIGN, 1'b1);
        evts(1, OC_OVR, 1'b1);
        evts(1, OC_CLEAN, 1'b0);
        rd_exp(8'h72, 4, "R7 good qualify");
        rd_exp(8'h73, 0, "R8 shadow high");
        rd_exp(8'h79, 1, "R6 overrun counted");

        // Enable gating: R5
        stat_en = 1'b0;
        evts(5, OC_OVR, 1'b1);
        evts(5, OC_CLEAN, 1'b1);
        rd_exp(8'h79, 0, "R5 lost gated");
        rd_exp(8'h72, 0, "R5 good gated");
        stat_en = 1'b1;

        // Two-byte read and threshold: R8, R4, R9
        evts(300, OC_CLEAN, 1'b1);
        check(upd_irq == 1'b1, "R4 good reached 0xC0", int'(upd_irq), 1);
        rd_exp(8'h72, 8'h2C, "R8 low byte");
        rd_exp(8'h73, 8'h01, "R8 shadow byte");
        rd_exp(8'h72, 0, "R8 cleared");
        rd_exp(8'h40, 1, "R4 flag register");
        wr_reg(8'h40, 8'h00);
        check(upd_irq == 1'b1, "R9 write 0 keeps flag", int'(upd_irq), 1);
        wr_reg(8'h40, 8'h01);
        check(upd_irq == 1'b0, "R9 write 1 clears", int'(upd_irq), 0);

        // Writes ignored, unmapped reads: R11
        evts(2, OC_OVR, 1'b1);
        wr_reg(8'h79, 8'h55);
        wr_reg(8'h72, 8'hAA);
        wr_reg(8'h73, 8'h5A);
        rd_exp(8'h79, 2, "R11 lost write ignored");
        rd_exp(8'h72, 0, "R11 good write ignored");
        rd_exp(8'h73, 0, "R11 shadow write ignored");
        rd_exp(8'h10, 0, "R11 unmapped read");

        // Read together with event: R10
        evts(5, OC_OVR, 1'b1);
        cyc(1'b1, OC_OVR, 1'b1, 1'b1, 1'b0, 8'h79, 8'h00);
        check(last_rd == 8'd5, "R10 old value returned", int'(last_rd), 5);
        rd_exp(8'h79, 1, "R10 counter left at one");

        // Lost threshold, raise beats clear, wrap: R4, R9, R1
        evts(191, OC_OVR, 1'b1);
        check(upd_irq == 1'b0, "R4 no flag at 0xBF", int'(upd_irq), 0);
        cyc(1'b1, OC_OVR, 1'b1, 1'b0, 1'b1, 8'h40, 8'h01);
        check(upd_irq == 1'b1, "R9 raise wins over clear", int'(upd_irq), 1);
        evts(63, OC_OVR, 1'b1);
        evts(1, OC_OVR, 1'b1);
        rd_exp(8'h79, 0, "R1 wrap to zero");
        wr_reg(8'h40, 8'h01);

        // Good counter full wrap: R2
        evts(65536, OC_CLEAN, 1'b1);
        check(upd_irq == 1'b1, "R4 flag during good run", int'(upd_irq), 1);
        rd_exp(8'h72, 0, "R2 wrap low byte");
        rd_exp(8'h73, 0, "R2 wrap high byte");

        finish_run();
    end

endmodule